// File: doc/BRIEF.md
# Multi-Size Shift and Rotate Unit

This unit runs the shift group of a 32-bit instruction set that has no registers. One opcode byte chooses the operand size and the operation. The operand is the value read from the instruction's destination location, and the shift count comes from the low bits of the source address field. The unit returns the value to write back to that location, together with an updated carry flag.

It covers four operand sizes (8, 16, 32 and 64 bits) and seven operations:

- left shift
- logical right shift
- arithmetic right shift
- plain rotate, left and right
- rotate through carry, left and right

Opcodes outside the group, and the one reserved operation code, are reported as illegal. In that case the operand is passed back unchanged.

Inputs are sampled on a clock edge when `in_valid` is high. The result, carry and illegal flag are registered and appear one cycle later with `out_valid`. They hold their values until the next valid input arrives.

Top module: `shift_rotate_unit`

## Requirements
- R1: For each cycle in which `in_valid` is sampled high, `out_valid` is high in the following cycle. `result`, `carry_out` and `illegal_op` belong to that input in that same cycle. `out_valid` is low in a cycle that follows a sample of `in_valid` low.
- R2: Opcode bits [7:5] equal to 111 mark the shift group. Bits [4:3] give the size: 00 is 8 bits (0xE0–0xE7), 01 is 16 bits (0xE8–0xEF), 10 is 32 bits (0xF0–0xF7) and 11 is 64 bits (0xF8–0xFF). Only the low N bits of `operand` are used, and every `result` bit at or above N is zero.
- R3: Operation code 0 (opcode bits [2:0]) is a left shift by the count. Carry takes the last bit shifted out. For counts above N, both the result and the carry are zero.
- R4: Code 1 is a logical right shift. Carry takes the last bit shifted out. For counts above N, both the result and the carry are zero.
- R5: Code 3 is an arithmetic right shift. Carry takes the last bit shifted out. For counts at or above N, every result bit and the carry equal the operand's sign bit.
- R6: Code 4 rotates left and code 5 rotates right, with the count taken modulo N. Carry equals the last bit carried around: the result LSB after a left rotate, the result MSB after a right rotate.
- R7: Code 6 rotates left and code 7 rotates right through an (N+1)-bit ring. The ring has the carry above the operand MSB, and the count is taken modulo N+1. The ring's top bit becomes `carry_out`.
- R8: A count of zero on any legal opcode returns the N-bit operand (upper bits zero) and leaves the carry equal to `carry_in`.
- R9: When opcode bits [7:5] are not 111, or bits [2:0] equal 2, `illegal_op` is 1, `result` equals the full `operand` and `carry_out` equals `carry_in`. For every other opcode, `illegal_op` is 0.
- R10: While `in_valid` is low, `result`, `carry_out` and `illegal_op` keep their values whatever the other inputs do.
- R11: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are presented this cycle |
| opcode | input | 8 | Instruction opcode byte |
| shift_count | input | CNT_W | Shift or rotate count |
| operand | input | 64 | Value read from the destination location |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered for the input sampled one cycle earlier |
| result | output | 64 | Value to write back |
| carry_out | output | 1 | Updated carry flag |
| illegal_op | output | 1 | Opcode is outside the group or reserved |

## Verification
Every result is due exactly one clock edge after its inputs are sampled. The bench therefore drives the inputs on a falling edge and compares all four outputs on the next falling edge, half a period after the capturing edge. The sweep covers all 32 shift-group opcodes, every count from 0 to 127 and three operand patterns with both carry values. That range includes the counts N and N+1 at which the plain shifts, the rotates and the ring rotates wrap. The hold cases drop `in_valid`, change every other input, and check one falling edge later that the outputs have not moved.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int DATA_W    = 64;
    localparam int NUM_SIZES = 4;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_RSV = 3'd2,
        OP_ASR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RCL = 3'd6,
        OP_RCR = 3'd7
    } sru_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } sru_size_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              carry;
        logic              illegal;
    } sru_state_t;

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
(
    input  logic [7:0] opcode,
    output sru_op_e    op,
    output sru_size_e  size,
    output logic       illegal
);

    logic in_group;

    always_comb begin
        in_group = (opcode[7:5] == 3'b111);
        op       = sru_op_e'(opcode[2:0]);
        size     = sru_size_e'(opcode[4:3]);
        illegal  = !in_group || (op == OP_RSV);
    end

endmodule

// File: rtl/sru_lane.sv
module sru_lane
    import sru_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 7,
    parameter int OUT_W = 64
) (
    input  sru_op_e            op,
    input  logic [CNT_W-1:0]   count,
    input  logic [W-1:0]       value,
    input  logic               carry_in,
    output logic [OUT_W-1:0]   res_ext,
    output logic               carry_out
);

    localparam logic [CNT_W-1:0] W_C  = CNT_W'(W);
    localparam logic [CNT_W-1:0] W1_C = CNT_W'(W + 1);

    logic [CNT_W-1:0] rot_amt;
    logic [CNT_W-1:0] ring_amt;
    logic [CNT_W-1:0] asr_amt;
    logic [W:0]       shl_x;
    logic [W:0]       shr_x;
    logic [W:0]       asr_x;
    logic [W-1:0]     rol_v;
    logic [W-1:0]     ror_v;
    logic [W:0]       ring;
    logic [W:0]       rcl_v;
    logic [W:0]       rcr_v;
    logic [W-1:0]     res_n;

    always_comb begin
        rot_amt  = count % W_C;
        ring_amt = count % W1_C;
        asr_amt  = (count >= W_C) ? W_C : count;

        // one spare bit beside the operand catches the last bit out
        shl_x = {1'b0, value} << count;
        shr_x = {value, 1'b0} >> count;
        asr_x = $unsigned($signed({value, 1'b0}) >>> asr_amt);

        rol_v = (value << rot_amt) | (value >> (W_C - rot_amt));
        ror_v = (value >> rot_amt) | (value << (W_C - rot_amt));

        ring  = {carry_in, value};
        rcl_v = (ring << ring_amt) | (ring >> (W1_C - ring_amt));
        rcr_v = (ring >> ring_amt) | (ring << (W1_C - ring_amt));

        res_n     = value;
        carry_out = carry_in;
        unique case (op)
            OP_SHL: begin res_n = shl_x[W-1:0]; carry_out = shl_x[W];   end
            OP_SHR: begin res_n = shr_x[W:1];   carry_out = shr_x[0];   end
            OP_ASR: begin res_n = asr_x[W:1];   carry_out = asr_x[0];   end
            OP_ROL: begin res_n = rol_v;        carry_out = rol_v[0];   end
            OP_ROR: begin res_n = ror_v;        carry_out = ror_v[W-1]; end
            OP_RCL: begin res_n = rcl_v[W-1:0]; carry_out = rcl_v[W];   end
            OP_RCR: begin res_n = rcr_v[W-1:0]; carry_out = rcr_v[W];   end
            default: begin res_n = value;       carry_out = carry_in;   end
        endcase

        if (count == '0) begin
            res_n     = value;
            carry_out = carry_in;
        end

        res_ext = OUT_W'(res_n);
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [CNT_W-1:0]  shift_count,
    input  logic [63:0]       operand,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic              carry_out,
    output logic              illegal_op
);

    sru_op_e    dec_op;
    sru_size_e  dec_size;
    logic       dec_illegal;

    logic [DATA_W-1:0] lane_res [NUM_SIZES];
    logic              lane_cy  [NUM_SIZES];

    sru_state_t st_d;
    sru_state_t st_q;

    sru_decode u_decode (
        .opcode  (opcode),
        .op      (dec_op),
        .size    (dec_size),
        .illegal (dec_illegal)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = 8 << g;
        sru_lane #(
            .W     (LW),
            .CNT_W (CNT_W),
            .OUT_W (DATA_W)
        ) u_lane (
            .op        (dec_op),
            .count     (shift_count),
            .value     (operand[LW-1:0]),
            .carry_in  (carry_in),
            .res_ext   (lane_res[g]),
            .carry_out (lane_cy[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (dec_illegal) begin
                st_d.result  = operand;
                st_d.carry   = carry_in;
                st_d.illegal = 1'b1;
            end else begin
                st_d.result  = lane_res[dec_size];
                st_d.carry   = lane_cy[dec_size];
                st_d.illegal = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign result     = st_q.result;
    assign carry_out  = st_q.carry;
    assign illegal_op = st_q.illegal;

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
    parameter int CNT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [CNT_W-1:0]  shift_count,
    input logic [63:0]       operand,
    input logic              carry_in,
    input logic              out_valid,
    input logic [63:0]       result,
    input logic              carry_out,
    input logic              illegal_op
);

    logic legal_in;
    assign legal_in = (opcode[7:5] == 3'b111) && (opcode[2:0] != 3'd2);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:3] == 5'b11100 && opcode[2:0] != 3'd2)
        |=> (result[63:8] == '0));

    a_r8_zero_count_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal_in && shift_count == '0)
        |=> (carry_out == $past(carry_in)));

    a_r9_outside_group: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:5] != 3'b111)
        |=> (illegal_op && result == $past(operand) && carry_out == $past(carry_in)));

    a_r9_legal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal_in) |=> !illegal_op);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(illegal_op)));

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .opcode      (opcode),
    .shift_count (shift_count),
    .operand     (operand),
    .carry_in    (carry_in),
    .out_valid   (out_valid),
    .result      (result),
    .carry_out   (carry_out),
    .illegal_op  (illegal_op)
);

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;

    localparam int CNT_W = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [7:0]        opcode;
    logic [CNT_W-1:0]  shift_count;
    logic [63:0]       operand;
    logic              carry_in;
    logic              out_valid;
    logic [63:0]       result;
    logic              carry_out;
    logic              illegal_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shift_rotate_unit #(.CNT_W(CNT_W)) i_shift_rotate_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .opcode      (opcode),
        .shift_count (shift_count),
        .operand     (operand),
        .carry_in    (carry_in),
        .out_valid   (out_valid),
        .result      (result),
        .carry_out   (carry_out),
        .illegal_op  (illegal_op)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // bit-at-a-time reference built from the requirements
    function automatic void model(input logic [7:0] op, input int cnt,
                                  input logic [63:0] opnd, input logic cin,
                                  output logic [63:0] r, output logic c,
                                  output logic ill);
        int          w;
        logic [63:0] v;
        logic [63:0] mask;
        logic        t;
        ill = (op[7:5] != 3'b111) || (op[2:0] == 3'd2);
        if (ill) begin
            r = opnd;
            c = cin;
            return;
        end
        w    = 8 << op[4:3];
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        v    = opnd & mask;
        c    = cin;
        for (int i = 0; i < cnt; i++) begin
            case (op[2:0])
                3'd0: begin c = v[w-1]; v = v << 1; end
                3'd1: begin c = v[0]; v = v >> 1; end
                3'd3: begin c = v[0]; t = v[w-1]; v = v >> 1; v[w-1] = t; end
                3'd4: begin t = v[w-1]; v = v << 1; v[0] = t; c = t; end
                3'd5: begin t = v[0]; v = v >> 1; v[w-1] = t; c = t; end
                3'd6: begin t = v[w-1]; v = v << 1; v[0] = c; c = t; end
                default: begin t = v[0]; v = v >> 1; v[w-1] = c; c = t; end
            endcase
            v = v & mask;
        end
        r = v;
    endfunction

    function automatic string req_of(input logic [7:0] op, input int cnt);
        if ((op[7:5] != 3'b111) || (op[2:0] == 3'd2)) return "R9";
        if (cnt == 0) return "R8";
        case (op[2:0])
            3'd0: return "R3";
            3'd1: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // called at a falling edge; returns at the next falling edge after checking
    task automatic apply(input logic [7:0] op, input int cnt,
                         input logic [63:0] opnd, input logic cin);
        logic [63:0] er;
        logic        ec;
        logic        ei;
        string       rq;
        int          w;
        in_valid    = 1'b1;
        opcode      = op;
        shift_count = CNT_W'(cnt);
        operand     = opnd;
        carry_in    = cin;
        model(op, cnt, opnd, cin, er, ec, ei);
        rq = req_of(op, cnt);
        @(negedge clk);
        check("R1", "out_valid", 64'(out_valid), 64'd1);
        check(rq, $sformatf("result op=%h cnt=%0d", op, cnt), result, er);
        check(rq, $sformatf("carry op=%h cnt=%0d", op, cnt), 64'(carry_out), 64'(ec));
        check(rq, $sformatf("illegal op=%h", op), 64'(illegal_op), 64'(ei));
        if (!ei) begin
            w = 8 << op[4:3];
            if (w < 64) check("R2", $sformatf("upper bits op=%h", op), result >> w, 64'd0);
        end
    endtask

    task automatic hold_case(input logic [7:0] op, input int cnt,
                             input logic [63:0] opnd, input logic cin);
        logic [63:0] r0;
        logic        c0;
        logic        i0;
        apply(op, cnt, opnd, cin);
        r0 = result;
        c0 = carry_out;
        i0 = illegal_op;
        in_valid    = 1'b0;
        opcode      = ~op;
        shift_count = ~CNT_W'(cnt);
        operand     = ~opnd;
        carry_in    = ~cin;
        @(negedge clk);
        check("R1", "out_valid low", 64'(out_valid), 64'd0);
        check("R10", "result held", result, r0);
        check("R10", "carry held", 64'(carry_out), 64'(c0));
        check("R10", "illegal held", 64'(illegal_op), 64'(i0));
    endtask

    initial begin
        logic [63:0] pats [3];
        pats[0] = 64'h8F3C_5A71_E0D2_9B46;
        pats[1] = 64'h7ED1_0369_42B8_5CA7;
        pats[2] = 64'hC000_0000_8000_0081;

        rst_n       = 1'b0;
        in_valid    = 1'b0;
        opcode      = 8'h00;
        shift_count = '0;
        operand     = '0;
        carry_in    = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "out_valid", 64'(out_valid), 64'd0);
        check("R11", "result", result, 64'd0);
        check("R11", "carry_out", 64'(carry_out), 64'd0);
        check("R11", "illegal_op", 64'(illegal_op), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < 3; p++)
            for (int o = 0; o < 32; o++)
                for (int c = 0; c < 128; c++)
                    apply(8'(8'hE0 + o), c, pats[p], 1'(p[0] ^ c[0]));

        // R9: opcodes outside the group and the reserved code
        for (int k = 0; k < 256; k++)
            if (k < 8'hE0 || k[2:0] == 3'd2)
                apply(8'(k), k % 128, pats[k % 3], 1'(k[1]));

        // R10: outputs hold while in_valid is low
        hold_case(8'hF6, 20, pats[0], 1'b1);
        hold_case(8'hEB, 16, pats[2], 1'b0);
        hold_case(8'h42, 3, pats[1], 1'b1);
        hold_case(8'hFD, 0, pats[1], 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule